// File: doc/BRIEF.md
# Key-Protected Independent Watchdog Timer

This block is a watchdog that keeps running from its own slow clock, independent of the bus clock that configures it. Software controls it through four word-wide registers on the bus side: a command register that accepts 16-bit key codes, a 3-bit divider select, a 12-bit reload value and a two-flag status word. The watchdog starts only when a start key is written. After that it cannot be stopped by any command. Software must keep writing a refresh key, or the down counter expires and the block pulses a reset request.

The divider and reload registers are write-protected. They accept writes only after an unlock key has been written. Each accepted write is carried into the watchdog clock domain by a toggle handshake through two-flop synchronisers. While that transfer is in flight, a busy flag for that register is set, and further writes to the register are dropped.

Top module: `wdt_keyed`

## Requirements
- R1: After reset, the divider register reads 0, the reload register reads 0xFFF, the status register reads 0 and the reset request is low.
- R2: Register addresses are 0 for command (reads 0), 1 for the divider select (bits 2:0) and 2 for the reload value (bits 11:0). Address 3 is status, with bit 0 set while a divider update is busy and bit 1 set while a reload update is busy.
- R3: Command value 0x5555 unlocks the divider and reload registers. Values 0xAAAA and 0xCCCC leave the lock state unchanged. Any other command value locks them. A write to either register while locked leaves its read-back value unchanged.
- R4: Only bits 11:0 of a reload write are stored and only bits 2:0 of a divider write; the other bits read back as 0.
- R5: An accepted divider or reload write sets that register's busy flag on the next bus clock. The flag clears once the watchdog domain has captured the value. A write to that register while its flag is set is ignored.
- R6: Before command 0xCCCC (start) is written, the reset request never rises.
- R7: Once started, the watchdog keeps running whatever command values follow.
- R8: While no refresh is issued, consecutive reset requests are (R+1)·D watchdog clock cycles apart. R is the reload value. D is 4·2^c for a divider code c from 0 to 6, and 256 for code 7.
- R9: Each reset request lasts exactly one watchdog clock cycle.
- R10: Command 0xAAAA (refresh) reloads the counter from the reload value and restarts the divider. Refreshing faster than the timeout keeps the reset request low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| wr_en | input | 1 | Register write strobe, one bus cycle per write |
| wr_addr | input | 2 | Write register select |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read register select |
| rd_data | output | 16 | Read data, combinational from rd_addr |
| wclk | input | 1 | Watchdog counter clock |
| wdt_rst_req | output | 1 | Single-cycle reset request in the wclk domain |

## Verification
The checks assume that rst_n is held low across several edges of both clocks, so that every synchroniser starts from zero. They also assume refresh commands are spaced more than a few watchdog clock cycles apart, because two toggles inside one synchroniser window would merge. The bench keeps to this: it issues refreshes at least 30 watchdog cycles apart and polls the busy flags before each configuration write. The one write that deliberately hits a busy register targets the divider, where the drop is the behaviour under test.

// File: rtl/wdt_keyed_pkg.sv
package wdt_keyed_pkg;
  localparam int ADDR_W = 2;
  localparam int DATA_W = 16;
  localparam int RLD_W  = 12;
  localparam int PSC_W  = 3;
  localparam int PCNT_W = 8;
  localparam int DIV_W  = PCNT_W + 1;
  localparam int MAX_SHIFT = 6;

  localparam logic [ADDR_W-1:0] SEL_CMD  = 2'd0;
  localparam logic [ADDR_W-1:0] SEL_PSC  = 2'd1;
  localparam logic [ADDR_W-1:0] SEL_RLD  = 2'd2;
  localparam logic [ADDR_W-1:0] SEL_STAT = 2'd3;

  localparam logic [DATA_W-1:0] KEY_UNLOCK = 16'h5555;
  localparam logic [DATA_W-1:0] KEY_KICK   = 16'hAAAA;
  localparam logic [DATA_W-1:0] KEY_START  = 16'hCCCC;

  // divide ratio: 4 doubled per code step, saturating at code 6
  function automatic logic [DIV_W-1:0] div_ratio(input logic [PSC_W-1:0] code);
    int sh;
    sh = (int'(code) > MAX_SHIFT) ? MAX_SHIFT : int'(code);
    return DIV_W'(4 << sh);
  endfunction
endpackage

// File: rtl/wdt_sync.sv
module wdt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '0;
    else        pipe <= {pipe[STAGES-2:0], d};
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/wdt_bus_regs.sv
module wdt_bus_regs
  import wdt_keyed_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              psc_ack_s,
  input  logic              rld_ack_s,
  output logic [PSC_W-1:0]  psc_q,
  output logic [RLD_W-1:0]  rld_q,
  output logic              psc_req,
  output logic              rld_req,
  output logic              kick_req,
  output logic              start_lvl,
  output logic              unlock,
  output logic              psc_busy,
  output logic              rld_busy,
  output logic              psc_acc,
  output logic              rld_acc
);
  logic cmd_wr;

  assign cmd_wr   = wr_en && (wr_addr == SEL_CMD);
  assign psc_busy = psc_req ^ psc_ack_s;
  assign rld_busy = rld_req ^ rld_ack_s;
  assign psc_acc  = wr_en && (wr_addr == SEL_PSC) && unlock && !psc_busy;
  assign rld_acc  = wr_en && (wr_addr == SEL_RLD) && unlock && !rld_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlock    <= 1'b0;
      kick_req  <= 1'b0;
      start_lvl <= 1'b0;
      psc_q     <= '0;
      rld_q     <= '1;
      psc_req   <= 1'b0;
      rld_req   <= 1'b0;
    end else begin
      if (cmd_wr) begin
        case (wr_data)
          KEY_UNLOCK: unlock    <= 1'b1;
          KEY_KICK:   kick_req  <= ~kick_req;
          KEY_START:  start_lvl <= 1'b1;
          default:    unlock    <= 1'b0;
        endcase
      end
      if (psc_acc) begin
        psc_q   <= wr_data[PSC_W-1:0];
        psc_req <= ~psc_req;
      end
      if (rld_acc) begin
        rld_q   <= wr_data[RLD_W-1:0];
        rld_req <= ~rld_req;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      SEL_PSC:  rd_data[PSC_W-1:0] = psc_q;
      SEL_RLD:  rd_data[RLD_W-1:0] = rld_q;
      SEL_STAT: rd_data[1:0]       = {rld_busy, psc_busy};
      default:  rd_data            = '0;
    endcase
  end
endmodule

// File: rtl/wdt_core.sv
module wdt_core
  import wdt_keyed_pkg::*;
(
  input  logic             wclk,
  input  logic             rst_n,
  input  logic [PSC_W-1:0] psc_q,
  input  logic [RLD_W-1:0] rld_q,
  input  logic             psc_req_s,
  input  logic             rld_req_s,
  input  logic             kick_s,
  input  logic             start_s,
  output logic             psc_ack,
  output logic             rld_ack,
  output logic             running,
  output logic             tick,
  output logic             rst_req
);
  logic [PSC_W-1:0]  wd_psc;
  logic [RLD_W-1:0]  wd_rld;
  logic [RLD_W-1:0]  cnt;
  logic [PCNT_W-1:0] pcnt;
  logic              kick_d;
  logic              psc_new, rld_new, kick_ev;
  logic [RLD_W-1:0]  rld_use;
  logic [DIV_W-1:0]  div_m1;

  assign running = start_s;
  assign psc_new = psc_req_s ^ psc_ack;
  assign rld_new = rld_req_s ^ rld_ack;
  assign kick_ev = kick_s ^ kick_d;
  assign rld_use = rld_new ? rld_q : wd_rld;
  assign div_m1  = div_ratio(wd_psc) - DIV_W'(1);
  assign tick    = running && ({1'b0, pcnt} >= div_m1);

  // capture crossed configuration; data was held stable by the busy lock
  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wd_psc  <= '0;
      wd_rld  <= '1;
      psc_ack <= 1'b0;
      rld_ack <= 1'b0;
      kick_d  <= 1'b0;
    end else begin
      kick_d <= kick_s;
      if (psc_new) begin
        wd_psc  <= psc_q;
        psc_ack <= psc_req_s;
      end
      if (rld_new) begin
        wd_rld  <= rld_q;
        rld_ack <= rld_req_s;
      end
    end
  end

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '1;
      pcnt    <= '0;
      rst_req <= 1'b0;
    end else if (kick_ev) begin
      cnt     <= rld_use;
      pcnt    <= '0;
      rst_req <= 1'b0;
    end else if (tick) begin
      pcnt <= '0;
      if (cnt == '0) begin
        rst_req <= 1'b1;
        cnt     <= rld_use;
      end else begin
        rst_req <= 1'b0;
        cnt     <= cnt - RLD_W'(1);
      end
    end else begin
      rst_req <= 1'b0;
      if (running) pcnt <= pcnt + PCNT_W'(1);
    end
  end
endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed
  import wdt_keyed_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wclk,
  output logic              wdt_rst_req
);
  logic [PSC_W-1:0] psc_q;
  logic [RLD_W-1:0] rld_q;
  logic psc_req, rld_req, kick_req, start_lvl, unlock;
  logic psc_busy, rld_busy, psc_acc, rld_acc;
  logic psc_ack, rld_ack, psc_ack_s, rld_ack_s;
  logic psc_req_s, rld_req_s, kick_s, start_s;
  logic running, tick;

  wdt_bus_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .psc_ack_s(psc_ack_s), .rld_ack_s(rld_ack_s),
    .psc_q(psc_q), .rld_q(rld_q), .psc_req(psc_req), .rld_req(rld_req),
    .kick_req(kick_req), .start_lvl(start_lvl), .unlock(unlock),
    .psc_busy(psc_busy), .rld_busy(rld_busy),
    .psc_acc(psc_acc), .rld_acc(rld_acc)
  );

  wdt_sync #(.STAGES(SYNC_STAGES)) u_s_psc   (.clk(wclk), .rst_n(rst_n), .d(psc_req),   .q(psc_req_s));
  wdt_sync #(.STAGES(SYNC_STAGES)) u_s_rld   (.clk(wclk), .rst_n(rst_n), .d(rld_req),   .q(rld_req_s));
  wdt_sync #(.STAGES(SYNC_STAGES)) u_s_kick  (.clk(wclk), .rst_n(rst_n), .d(kick_req),  .q(kick_s));
  wdt_sync #(.STAGES(SYNC_STAGES)) u_s_start (.clk(wclk), .rst_n(rst_n), .d(start_lvl), .q(start_s));
  wdt_sync #(.STAGES(SYNC_STAGES)) u_s_pack  (.clk(clk),  .rst_n(rst_n), .d(psc_ack),   .q(psc_ack_s));
  wdt_sync #(.STAGES(SYNC_STAGES)) u_s_rack  (.clk(clk),  .rst_n(rst_n), .d(rld_ack),   .q(rld_ack_s));

  wdt_core u_core (
    .wclk(wclk), .rst_n(rst_n), .psc_q(psc_q), .rld_q(rld_q),
    .psc_req_s(psc_req_s), .rld_req_s(rld_req_s), .kick_s(kick_s),
    .start_s(start_s), .psc_ack(psc_ack), .rld_ack(rld_ack),
    .running(running), .tick(tick), .rst_req(wdt_rst_req)
  );
endmodule

// File: rtl/wdt_keyed_chk.sv
module wdt_keyed_chk
  import wdt_keyed_pkg::*;
(
  input logic              clk,
  input logic              wclk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              unlock,
  input logic [PSC_W-1:0]  psc_q,
  input logic              psc_busy,
  input logic              psc_acc,
  input logic              running,
  input logic              wdt_rst_req
);
  a_r3_unlock_key: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == SEL_CMD && wr_data == KEY_UNLOCK) |=> unlock);

  a_r3_locked_psc_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == SEL_PSC && !unlock) |=> $stable(psc_q));

  a_r5_busy_from_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(psc_busy) |-> $past(psc_acc));

  a_r5_busy_drops_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == SEL_PSC && psc_busy) |=> $stable(psc_q));

  a_r6_idle_quiet: assert property (@(posedge wclk) disable iff (!rst_n)
    !running |-> !wdt_rst_req);

  a_r7_run_sticky: assert property (@(posedge wclk) disable iff (!rst_n)
    running |=> running);

  a_r9_single_pulse: assert property (@(posedge wclk) disable iff (!rst_n)
    wdt_rst_req |=> !wdt_rst_req);
endmodule

bind wdt_keyed wdt_keyed_chk u_chk (
  .clk(clk), .wclk(wclk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .unlock(unlock), .psc_q(psc_q), .psc_busy(psc_busy),
  .psc_acc(psc_acc), .running(running), .wdt_rst_req(wdt_rst_req)
);

// File: tb/sim_wdt_keyed.sv
module sim_wdt_keyed;
  logic        clk = 1'b0, wclk = 1'b0, rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0, rd_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        wdt_rst_req;

  int checks = 0, fails = 0;
  int wcyc = 0, pulse_cnt = 0, prev_t = 0, last_t = 0;
  bit done = 0;

  always #10 clk  = ~clk;   // 50 MHz bus clock
  always #16 wclk = ~wclk;  // watchdog clock

  wdt_keyed u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .wclk(wclk),
    .wdt_rst_req(wdt_rst_req));

  always @(posedge wclk) begin
    wcyc <= wcyc + 1;
    if (wdt_rst_req) begin
      pulse_cnt <= pulse_cnt + 1;
      prev_t    <= last_t;
      last_t    <= wcyc;
    end
  end

  function automatic int exp_div(input int code);
    return (code >= 6) ? 256 : 4 * (2 ** code);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  task automatic wait_idle(input int bitpos);
    logic [15:0] s;
    for (int i = 0; i < 200; i++) begin
      rd(2'd3, s);
      if (!s[bitpos]) return;
    end
    check(1'b0, "R5 busy never clears", int'(s), 0);
  endtask

  task automatic cfg(input int code, input int rv);
    wr(2'd0, 16'h5555);
    wr(2'd1, 16'(code));
    wait_idle(0);
    wr(2'd2, 16'(rv));
    wait_idle(1);
    wr(2'd0, 16'hAAAA);
    repeat (8) @(posedge wclk);
  endtask

  task automatic meas(output int per);
    int p0 = pulse_cnt;
    per = -1;
    for (int i = 0; i < 20000; i++) begin
      @(negedge wclk);
      if (pulse_cnt >= p0 + 2) begin
        per = last_t - prev_t;
        return;
      end
    end
  endtask

  initial begin
    #(20 * 190000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    int per, base, code, rv;
    void'($urandom(32'd1234));
    repeat (6) @(posedge wclk);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);

    // R1 reset state
    rd(2'd1, v); check(v == 16'h0,   "R1 divider reset", v, 0);
    rd(2'd2, v); check(v == 16'hFFF, "R1 reload reset", v, 16'hFFF);
    rd(2'd3, v); check(v == 16'h0,   "R1 status reset", v, 0);
    rd(2'd0, v); check(v == 16'h0,   "R2 command reads zero", v, 0);
    check(wdt_rst_req == 1'b0, "R1 request low", wdt_rst_req, 0);

    // R3 locked write ignored
    wr(2'd1, 16'h0003);
    rd(2'd1, v); check(v == 16'h0, "R3 locked divider write ignored", v, 0);

    // R5 busy set, write during busy dropped
    wr(2'd0, 16'h5555);
    wr(2'd1, 16'h0002);
    rd(2'd3, v); check(v[0] == 1'b1, "R5 divider busy set", v, 1);
    wr(2'd1, 16'h0005);
    wait_idle(0);
    rd(2'd1, v); check(v == 16'h2, "R5 write while busy ignored", v, 2);

    // R4 upper reload bits dropped
    wr(2'd2, 16'hF005);
    wait_idle(1);
    rd(2'd2, v); check(v == 16'h005, "R4 reload upper bits", v, 5);
    wr(2'd1, 16'hFFF9);
    wait_idle(0);
    rd(2'd1, v); check(v == 16'h1, "R4 divider upper bits", v, 1);

    // R3 other value relocks
    wr(2'd0, 16'h1234);
    wr(2'd2, 16'h0077);
    rd(2'd2, v); check(v == 16'h005, "R3 relocked reload write ignored", v, 5);

    // R6 idle before start, even with a short period configured
    cfg(0, 0);
    repeat (300) @(posedge wclk);
    check(pulse_cnt == 0, "R6 no request before start", pulse_cnt, 0);

    // start
    wr(2'd0, 16'hCCCC);
    cfg(0, 3);
    meas(per); check(per == 16, "R8 period code0 R3", per, 16);

    // R8 code 7 saturates at 256
    cfg(7, 1);
    meas(per); check(per == 512, "R8 code7 period", per, 512);

    // R7 lock command does not stop counting
    cfg(0, 5);
    wr(2'd0, 16'h0000);
    meas(per); check(per == 24, "R7 still running after other command", per, 24);

    // R8 random configurations
    for (int t = 0; t < 6; t++) begin
      code = $urandom % 8;
      rv   = $urandom % 8;
      cfg(code, rv);
      meas(per);
      check(per == (rv + 1) * exp_div(code), "R8 random period", per, (rv + 1) * exp_div(code));
    end

    // R10 refresh keeps request low
    cfg(1, 7);
    base = pulse_cnt;
    for (int k = 0; k < 16; k++) begin
      wr(2'd0, 16'hAAAA);
      repeat (30) @(posedge wclk);
    end
    check(pulse_cnt == base, "R10 refresh holds off request", pulse_cnt - base, 0);
    repeat (100) @(posedge wclk);
    check(pulse_cnt > base, "R10 request after refresh stops", pulse_cnt - base, 1);

    // R9 pulse width: request is low one cycle after a pulse
    for (int i = 0; i < 200; i++) begin
      @(negedge wclk);
      if (wdt_rst_req) break;
    end
    @(negedge wclk);
    check(wdt_rst_req == 1'b0, "R9 one-cycle request", wdt_rst_req, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule